// File: doc/BRIEF.md
# Greedy Spare-Cell Pairing Engine

This block decides, for a reconfigurable cell array, which unused spare cell will stand in for each faulty (forbidden) cell. Software or a configuration controller writes the row/column coordinates of the forbidden cells and of the spare cells into two small on-block coordinate tables. It then pulses `start` with the number of valid entries in each table. The engine takes the forbidden cells in table order. For each one it scans every spare, one spare per clock. It keeps the still-unclaimed spare whose relocation distance is smallest, which is the length of the horizontal shift segment plus the length of the vertical shift segment. That spare is then claimed and cannot be chosen again.

Each decision leaves the block as a one-cycle strobe. The strobe carries the forbidden index, the chosen spare index, the pair cost and a three-bit relocation-direction code, and a running total cost is updated with it. A request that has more forbidden cells than spares is rejected at once. A request with no forbidden cells is reported at once as the identity mapping with zero cost. Carrying out the cell index shifts belongs to a later stage.

Top module: `spare_pair_greedy`

## Requirements
- R1: After reset, `busy`, `pair_valid`, `done`, `fail` and `identity` are 0 and `total_cost` is 0.
- R2: When `start` is sampled with `fb_num > sp_num`, then after that edge `done` and `fail` are 1, `identity` is 0, `total_cost` is 0, and no `pair_valid` strobe follows.
- R3: When `start` is sampled with `fb_num == 0`, then after that edge `done` and `identity` are 1, `fail` is 0, `total_cost` is 0, and no `pair_valid` strobe follows.
- R4: Let S be `sp_num` and F be `fb_num`, with 1 <= F <= S. Count the start edge as edge 0. The pair for forbidden entry k (counting from 0) is strobed by a one-cycle `pair_valid` after edge (k+1)*S. `pair_fb` equals k, so pairs leave in table order, and no strobe appears at any other edge.
- R5: The chosen spare is one not yet claimed in this run and has the smallest cost among unclaimed spares. When several unclaimed spares share that cost, the lowest spare index is chosen.
- R6: No spare index is reported in more than one pair of a run.
- R7: `pair_cost` equals |spare row − forbidden row| + |spare column − forbidden column|.
- R8: `pair_case` encodes the spare's position relative to the forbidden cell. Let dr be the row distance and dc the column distance. If |dr| > |dc|, the case is vertical-led: bit2=1, bit1 = spare row greater (south), bit0 = spare column smaller (west). Otherwise it is horizontal-led: bit2=0, bit1 = spare column smaller (west), bit0 = spare row smaller (north).
- R9: `total_cost` is cleared by the start edge. Each strobe adds that pair's `pair_cost` to it in the same cycle, so after the run it equals the sum of all pair costs.
- R10: `busy` is 1 after edges 0 to F*S−1 of a pairing run and 0 from edge F*S. `done` rises after edge F*S+1 and stays at 1 until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_we | input | 1 | Write strobe for the forbidden-cell table |
| fb_waddr | input | FIW | Forbidden table entry to write |
| fb_wrow | input | COORD_W | Row of the forbidden cell |
| fb_wcol | input | COORD_W | Column of the forbidden cell |
| sp_we | input | 1 | Write strobe for the spare-cell table |
| sp_waddr | input | SIW | Spare table entry to write |
| sp_wrow | input | COORD_W | Row of the spare cell |
| sp_wcol | input | COORD_W | Column of the spare cell |
| start | input | 1 | Begin a run; accepted only while not busy |
| fb_num | input | FCW | Number of valid forbidden entries (0..FB_DEPTH) |
| sp_num | input | SCW | Number of valid spare entries (0..SP_DEPTH) |
| busy | output | 1 | Run in progress |
| pair_valid | output | 1 | One-cycle strobe for a decided pair |
| pair_fb | output | FIW | Forbidden entry index of the pair |
| pair_sp | output | SIW | Spare entry index of the pair |
| pair_case | output | 3 | Relocation-direction code |
| pair_cost | output | COORD_W+1 | Relocation distance of the pair |
| total_cost | output | TW | Accumulated cost of the run |
| done | output | 1 | Run finished; held until next start |
| fail | output | 1 | Run rejected: too few spares |
| identity | output | 1 | Run had no forbidden cells |

## Verification
All results are registered. A rejected or empty request shows its flags after the start edge itself. The pair for forbidden entry k is due after edge (k+1)·S, because each spare costs exactly one scan cycle. `done` is due one edge after the last pair. The bench drives on falling edges and counts rising edges from the start edge. At every edge of a run it compares the strobe and its fields with a greedy model computed in the bench. The check happens only at the edge the timing rule predicts, and a strobe at any other edge counts as an error.

// File: rtl/spg_pkg.sv
package spg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SCAN   = 2'd1,
    SEQ_FINISH = 2'd2
  } seq_state_t;

  // Relocation-direction codes
  localparam logic [2:0] CASE_H_EAST_SOUTH = 3'd0;
  localparam logic [2:0] CASE_H_EAST_NORTH = 3'd1;
  localparam logic [2:0] CASE_H_WEST_SOUTH = 3'd2;
  localparam logic [2:0] CASE_H_WEST_NORTH = 3'd3;
  localparam logic [2:0] CASE_V_NORTH_EAST = 3'd4;
  localparam logic [2:0] CASE_V_NORTH_WEST = 3'd5;
  localparam logic [2:0] CASE_V_SOUTH_EAST = 3'd6;
  localparam logic [2:0] CASE_V_SOUTH_WEST = 3'd7;

endpackage

// File: rtl/spg_coord_ram.sv
// Coordinate table: one synchronous write port, one asynchronous read port
// (maps onto distributed RAM).
module spg_coord_ram #(
  parameter int DEPTH   = 8,
  parameter int AW      = 3,
  parameter int COORD_W = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [COORD_W-1:0] wrow,
  input  logic [COORD_W-1:0] wcol,
  input  logic [AW-1:0]      raddr,
  output logic [COORD_W-1:0] rrow,
  output logic [COORD_W-1:0] rcol
);
  localparam int EW = 2 * COORD_W;

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wrow, wcol};
  end

  logic [EW-1:0] rd_word;
  assign rd_word = mem[raddr];
  assign rrow    = rd_word[EW-1:COORD_W];
  assign rcol    = rd_word[COORD_W-1:0];
endmodule

// File: rtl/spg_cost_unit.sv
// Distance and direction code of one forbidden/spare pair.
module spg_cost_unit
  import spg_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] f_row,
  input  logic [COORD_W-1:0] f_col,
  input  logic [COORD_W-1:0] s_row,
  input  logic [COORD_W-1:0] s_col,
  output logic [COORD_W:0]   cost,
  output logic [2:0]         dcase
);
  logic [COORD_W-1:0] adr, adc;
  logic south, north, east, west, vert_led;

  always_comb begin
    south    = s_row > f_row;
    north    = s_row < f_row;
    east     = s_col > f_col;
    west     = s_col < f_col;
    adr      = south ? (s_row - f_row) : (f_row - s_row);
    adc      = east  ? (s_col - f_col) : (f_col - s_col);
    cost     = {1'b0, adr} + {1'b0, adc};
    vert_led = adr > adc;
    if (vert_led) dcase = {1'b1, south, west};
    else          dcase = {1'b0, west, north};
  end
endmodule

// File: rtl/spg_best_tracker.sv
// Holds the cheapest free candidate seen in the current scan.
module spg_best_tracker #(
  parameter int CW  = 5,
  parameter int SIW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           restart,
  input  logic           cand_ok,
  input  logic [CW-1:0]  cand_cost,
  input  logic [SIW-1:0] cand_idx,
  input  logic [2:0]     cand_case,
  output logic [CW-1:0]  nxt_cost,
  output logic [SIW-1:0] nxt_idx,
  output logic [2:0]     nxt_case
);
  logic           have;
  logic [CW-1:0]  held_cost;
  logic [SIW-1:0] held_idx;
  logic [2:0]     held_case;
  logic           take;

  always_comb begin
    // strict less-than keeps the earliest (lowest index) among equals
    take     = cand_ok && (!have || (cand_cost < held_cost));
    nxt_cost = take ? cand_cost : held_cost;
    nxt_idx  = take ? cand_idx  : held_idx;
    nxt_case = take ? cand_case : held_case;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      have      <= 1'b0;
      held_cost <= '0;
      held_idx  <= '0;
      held_case <= '0;
    end else if (step) begin
      have      <= have | cand_ok;
      held_cost <= nxt_cost;
      held_idx  <= nxt_idx;
      held_case <= nxt_case;
    end
  end
endmodule

// File: rtl/spare_pair_greedy.sv
module spare_pair_greedy
  import spg_pkg::*;
#(
  parameter int FB_DEPTH = 8,
  parameter int SP_DEPTH = 8,
  parameter int COORD_W  = 4,
  localparam int FIW = (FB_DEPTH > 1) ? $clog2(FB_DEPTH) : 1,
  localparam int SIW = (SP_DEPTH > 1) ? $clog2(SP_DEPTH) : 1,
  localparam int FCW = $clog2(FB_DEPTH + 1),
  localparam int SCW = $clog2(SP_DEPTH + 1),
  localparam int PCW = COORD_W + 1,
  localparam int TW  = PCW + FCW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fb_we,
  input  logic [FIW-1:0]     fb_waddr,
  input  logic [COORD_W-1:0] fb_wrow,
  input  logic [COORD_W-1:0] fb_wcol,
  input  logic               sp_we,
  input  logic [SIW-1:0]     sp_waddr,
  input  logic [COORD_W-1:0] sp_wrow,
  input  logic [COORD_W-1:0] sp_wcol,
  input  logic               start,
  input  logic [FCW-1:0]     fb_num,
  input  logic [SCW-1:0]     sp_num,
  output logic               busy,
  output logic               pair_valid,
  output logic [FIW-1:0]     pair_fb,
  output logic [SIW-1:0]     pair_sp,
  output logic [2:0]         pair_case,
  output logic [PCW-1:0]     pair_cost,
  output logic [TW-1:0]      total_cost,
  output logic               done,
  output logic               fail,
  output logic               identity
);

  seq_state_t          state;
  logic [FCW-1:0]      f_num, fidx;
  logic [SCW-1:0]      s_num, sidx;
  logic [SP_DEPTH-1:0] used_mask;

  logic [COORD_W-1:0]  f_row, f_col, s_row, s_col;
  logic [PCW-1:0]      cand_cost, nxt_cost;
  logic [2:0]          cand_case, nxt_case;
  logic [SIW-1:0]      nxt_idx;
  logic [SIW-1:0]      s_addr;
  logic [FIW-1:0]      f_addr;
  logic                scanning, last_spare, last_fb, cand_free;

  assign f_addr     = fidx[FIW-1:0];
  assign s_addr     = sidx[SIW-1:0];
  assign scanning   = (state == SEQ_SCAN);
  assign last_spare = (sidx == s_num - SCW'(1));
  assign last_fb    = (fidx == f_num - FCW'(1));
  assign cand_free  = !used_mask[s_addr];

  spg_coord_ram #(.DEPTH(FB_DEPTH), .AW(FIW), .COORD_W(COORD_W)) u_fb_ram (
    .clk(clk), .we(fb_we), .waddr(fb_waddr), .wrow(fb_wrow), .wcol(fb_wcol),
    .raddr(f_addr), .rrow(f_row), .rcol(f_col)
  );

  spg_coord_ram #(.DEPTH(SP_DEPTH), .AW(SIW), .COORD_W(COORD_W)) u_sp_ram (
    .clk(clk), .we(sp_we), .waddr(sp_waddr), .wrow(sp_wrow), .wcol(sp_wcol),
    .raddr(s_addr), .rrow(s_row), .rcol(s_col)
  );

  spg_cost_unit #(.COORD_W(COORD_W)) u_cost (
    .f_row(f_row), .f_col(f_col), .s_row(s_row), .s_col(s_col),
    .cost(cand_cost), .dcase(cand_case)
  );

  spg_best_tracker #(.CW(PCW), .SIW(SIW)) u_best (
    .clk(clk), .rst(rst),
    .step(scanning), .restart(scanning && last_spare),
    .cand_ok(cand_free), .cand_cost(cand_cost), .cand_idx(s_addr),
    .cand_case(cand_case),
    .nxt_cost(nxt_cost), .nxt_idx(nxt_idx), .nxt_case(nxt_case)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      f_num      <= '0;
      s_num      <= '0;
      fidx       <= '0;
      sidx       <= '0;
      used_mask  <= '0;
      busy       <= 1'b0;
      pair_valid <= 1'b0;
      pair_fb    <= '0;
      pair_sp    <= '0;
      pair_case  <= '0;
      pair_cost  <= '0;
      total_cost <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
      identity   <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            f_num      <= fb_num;
            s_num      <= sp_num;
            fidx       <= '0;
            sidx       <= '0;
            used_mask  <= '0;
            total_cost <= '0;
            done       <= 1'b0;
            fail       <= 1'b0;
            identity   <= 1'b0;
            if ({1'b0, fb_num} > {1'b0, sp_num[SCW-1:0]} + (FCW + 1)'(0)) begin
              done <= 1'b1;
              fail <= 1'b1;
            end else if (fb_num == '0) begin
              done     <= 1'b1;
              identity <= 1'b1;
            end else begin
              state <= SEQ_SCAN;
              busy  <= 1'b1;
            end
          end
        end
        SEQ_SCAN: begin
          if (last_spare) begin
            pair_valid         <= 1'b1;
            pair_fb            <= f_addr;
            pair_sp            <= nxt_idx;
            pair_case          <= nxt_case;
            pair_cost          <= nxt_cost;
            total_cost         <= total_cost + TW'(nxt_cost);
            used_mask[nxt_idx] <= 1'b1;
            sidx               <= '0;
            if (last_fb) begin
              state <= SEQ_FINISH;
              busy  <= 1'b0;
            end else begin
              fidx <= fidx + FCW'(1);
            end
          end else begin
            sidx <= sidx + SCW'(1);
          end
        end
        SEQ_FINISH: begin
          done  <= 1'b1;
          state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
  parameter int SP_DEPTH = 8,
  parameter int SIW      = 3,
  parameter int PCW      = 5,
  parameter int TW       = 9
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                pair_valid,
  input logic [SIW-1:0]      pair_sp,
  input logic [PCW-1:0]      pair_cost,
  input logic [TW-1:0]       total_cost,
  input logic                done,
  input logic                fail,
  input logic                identity,
  input logic [SP_DEPTH-1:0] used_mask
);

  p_fail_clean_r2: assert property (@(posedge clk) disable iff (rst)
    fail |-> (done && !identity && !pair_valid && total_cost == '0));

  p_identity_clean_r3: assert property (@(posedge clk) disable iff (rst)
    identity |-> (done && !fail && !pair_valid && total_cost == '0));

  // R6: the reported spare was unclaimed before this strobe
  p_spare_fresh_r6: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> ((($past(used_mask) >> pair_sp) & SP_DEPTH'(1)) == '0));

  p_claim_grows_r6: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> ($countones(used_mask) == $countones($past(used_mask)) + 1));

  p_total_accum_r9: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> (total_cost == $past(total_cost) + TW'(pair_cost)));

  p_valid_not_done_r10: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> !done);

  p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

endmodule

bind spare_pair_greedy spg_checker #(
  .SP_DEPTH(SP_DEPTH), .SIW(SIW), .PCW(PCW), .TW(TW)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .pair_valid(pair_valid),
  .pair_sp(pair_sp), .pair_cost(pair_cost), .total_cost(total_cost),
  .done(done), .fail(fail), .identity(identity), .used_mask(used_mask)
);

// File: tb/spare_pair_greedy_tb.sv
module spare_pair_greedy_tb;
  localparam int FBD = 8;
  localparam int SPD = 8;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic         fb_we = 0, sp_we = 0, start = 0;
  logic [2:0]   fb_waddr = 0, sp_waddr = 0;
  logic [3:0]   fb_wrow = 0, fb_wcol = 0, sp_wrow = 0, sp_wcol = 0;
  logic [3:0]   fb_num = 0, sp_num = 0;
  logic         busy, pair_valid, done, fail, identity;
  logic [2:0]   pair_fb, pair_sp, pair_case;
  logic [4:0]   pair_cost;
  logic [8:0]   total_cost;

  spare_pair_greedy #(.FB_DEPTH(FBD), .SP_DEPTH(SPD), .COORD_W(CW)) u_dut (
    .clk(clk), .rst(rst),
    .fb_we(fb_we), .fb_waddr(fb_waddr), .fb_wrow(fb_wrow), .fb_wcol(fb_wcol),
    .sp_we(sp_we), .sp_waddr(sp_waddr), .sp_wrow(sp_wrow), .sp_wcol(sp_wcol),
    .start(start), .fb_num(fb_num), .sp_num(sp_num),
    .busy(busy), .pair_valid(pair_valid), .pair_fb(pair_fb), .pair_sp(pair_sp),
    .pair_case(pair_case), .pair_cost(pair_cost), .total_cost(total_cost),
    .done(done), .fail(fail), .identity(identity)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int fr [FBD], fc [FBD], sr [SPD], sc [SPD];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int ref_case(input int a_r, input int a_c, input int b_r, input int b_c);
    int adr = iabs(b_r - a_r);
    int adc = iabs(b_c - a_c);
    if (adr > adc) return 4 + ((b_r > a_r) ? 2 : 0) + ((b_c < a_c) ? 1 : 0);
    return ((b_c < a_c) ? 2 : 0) + ((b_r < a_r) ? 1 : 0);
  endfunction

  task automatic load(input int nf, input int ns);
    for (int i = 0; i < nf; i++) begin
      fb_we = 1; fb_waddr = 3'(i); fb_wrow = 4'(fr[i]); fb_wcol = 4'(fc[i]);
      @(negedge clk);
    end
    fb_we = 0;
    for (int i = 0; i < ns; i++) begin
      sp_we = 1; sp_waddr = 3'(i); sp_wrow = 4'(sr[i]); sp_wcol = 4'(sc[i]);
      @(negedge clk);
    end
    sp_we = 0;
  endtask

  task automatic run(input int nf, input int ns);
    int exp_sp [FBD];
    int exp_cost [FBD];
    int exp_case [FBD];
    bit taken [SPD];
    int tot = 0;
    int stray = 0;
    load(nf, ns);
    for (int i = 0; i < SPD; i++) taken[i] = 0;
    if (nf <= ns) begin
      for (int k = 0; k < nf; k++) begin
        int best = -1;
        int bc = 0;
        for (int s = 0; s < ns; s++) begin
          int c = iabs(sr[s] - fr[k]) + iabs(sc[s] - fc[k]);
          if (!taken[s] && (best < 0 || c < bc)) begin best = s; bc = c; end
        end
        taken[best] = 1;
        exp_sp[k] = best; exp_cost[k] = bc;
        exp_case[k] = ref_case(fr[k], fc[k], sr[best], sc[best]);
        tot += bc;
      end
    end
    fb_num = 4'(nf); sp_num = 4'(ns); start = 1;
    @(posedge clk); @(negedge clk);
    start = 0;
    if (nf > ns) begin
      chk(done && fail && !identity, "R2", "done/fail/identity", {done, fail, identity}, 6);
      chk(total_cost == 0, "R2", "total_cost", total_cost, 0);
      for (int c = 0; c < 4; c++) begin
        @(posedge clk); @(negedge clk);
        if (pair_valid) stray++;
      end
      chk(stray == 0, "R2", "stray strobes", stray, 0);
      return;
    end
    if (nf == 0) begin
      chk(done && identity && !fail, "R3", "done/fail/identity", {done, fail, identity}, 5);
      chk(total_cost == 0, "R3", "total_cost", total_cost, 0);
      for (int c = 0; c < 4; c++) begin
        @(posedge clk); @(negedge clk);
        if (pair_valid) stray++;
      end
      chk(stray == 0, "R3", "stray strobes", stray, 0);
      return;
    end
    chk(busy && !done, "R10", "busy after start", {busy, done}, 2);
    for (int c = 1; c <= nf * ns + 1; c++) begin
      @(posedge clk); @(negedge clk);
      if (c % ns == 0 && c <= nf * ns) begin
        int k = c / ns - 1;
        chk(pair_valid == 1, "R4", "pair strobe", pair_valid, 1);
        chk(pair_fb == 3'(k), "R4", "pair_fb order", pair_fb, k);
        chk(pair_sp == 3'(exp_sp[k]), "R5", "chosen spare", pair_sp, exp_sp[k]);
        chk(pair_cost == 5'(exp_cost[k]), "R7", "pair_cost", pair_cost, exp_cost[k]);
        chk(pair_case == 3'(exp_case[k]), "R8", "pair_case", pair_case, exp_case[k]);
        chk(busy == (c < nf * ns), "R10", "busy", busy, int'(c < nf * ns));
      end else if (pair_valid) begin
        stray++;
      end
      if (c == nf * ns) chk(done == 0, "R10", "done early", done, 0);
    end
    chk(stray == 0, "R4", "strobes off schedule", stray, 0);
    chk(done == 1, "R10", "done after last pair", done, 1);
    chk(total_cost == 9'(tot), "R9", "total_cost", total_cost, tot);
    @(posedge clk); @(negedge clk);
    chk(done == 1, "R10", "done held", done, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !pair_valid && !done && !fail && !identity, "R1", "flags",
        {busy, pair_valid, done, fail, identity}, 0);
    chk(total_cost == 0, "R1", "total_cost", total_cost, 0);

    // R3 empty forbidden set
    sr[0] = 1; sc[0] = 1; sr[1] = 2; sc[1] = 2; sr[2] = 3; sc[2] = 3;
    run(0, 3);
    // R2 too few spares
    fr[0] = 1; fc[0] = 1; fr[1] = 5; fc[1] = 5; fr[2] = 9; fc[2] = 9;
    run(3, 2);

    // R5 tie: three spares at cost 2, lowest index wins, then next lowest
    fr[0] = 5; fc[0] = 5; fr[1] = 5; fc[1] = 5;
    sr[0] = 5; sc[0] = 7; sr[1] = 7; sc[1] = 5; sr[2] = 3; sc[2] = 5;
    run(2, 3);

    // R8 one spare in each direction code
    begin
      int rows [8] = '{8, 8, 6, 6, 4, 4, 12, 12};
      int cols [8] = '{10, 5, 11, 5, 8, 7, 9, 7};
      for (int d = 0; d < 8; d++) begin
        fr[0] = 8; fc[0] = 8; sr[0] = rows[d]; sc[0] = cols[d];
        run(1, 1);
      end
    end

    // R6 full table: every spare claimed once
    for (int i = 0; i < 8; i++) begin
      fr[i] = 7; fc[i] = 7; sr[i] = 15 - i; sc[i] = i;
    end
    run(8, 8);

    // random runs
    for (int t = 0; t < 30; t++) begin
      int ns = $urandom_range(1, SPD);
      int nf = $urandom_range(1, ns);
      for (int i = 0; i < FBD; i++) begin
        fr[i] = $urandom_range(0, 15); fc[i] = $urandom_range(0, 15);
      end
      for (int i = 0; i < SPD; i++) begin
        sr[i] = $urandom_range(0, 15); sc[i] = $urandom_range(0, 15);
      end
      run(nf, ns);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule